// File: doc/BRIEF.md
# Microstep Excitation Sequencer

This block tracks the electrical rotor angle of a two-phase stepper motor and turns it into two drive commands, one per winding. Each command has a polarity bit that picks the winding half to energise and an 8-bit amplitude code that downstream chopper logic turns into a current reference. The angle is a 6-bit position with 64 positions per electrical cycle, so one full step spans 16 positions. Position 8, where both windings carry equal current, is the origin.

Step strobes arrive from a separate edge-detection block as single-cycle pulses. Each accepted strobe moves the position by the stride of the active resolution, which runs from full step down to one sixteenth of a step. A direction bit sets the sense of travel. A two-bit resolution select and a flag that says whether the upstream detector counts both clock edges together choose one of five resolutions. Changing resolution never moves the rotor. The next strobe starts from the position already held.

A hold input freezes the sequencer. An active-low home input forces the origin, and an origin flag reports when the rotor sits there.

Top module: `msq_sequencer`

## Requirements
- R1: With `rst` high at a rising clock edge, the position becomes the origin (8). From the next edge on, `amp_a` = `amp_b` = 181, `pol_a` = `pol_b` = 0 and `at_origin` = 1.
- R2: With `home_n` low at a rising edge, the position becomes the origin. This happens even when `enable` is low.
- R3: The stride is chosen from `mode_sel` and `both_edge`. With `both_edge`=0, `mode_sel` 0/1/2/3 gives strides 16/8/4/2. With `both_edge`=1, the same codes give 8/4/2/1.
- R4: `dir`=0 adds to the position and `dir`=1 subtracts from it. The position wraps modulo 64.
- R5: Phase A follows a 17-entry quarter table T indexed by k = position mod 16. Quadrant 0 (positions 0..15) gives T[k] with polarity 0. Quadrant 1 gives T[16-k] with polarity 1. Quadrant 2 gives T[k] with polarity 1. Quadrant 3 gives T[16-k] with polarity 0. Phase B uses the same mapping applied to (position+48) mod 64, so it lags phase A by a quarter cycle.
- R6: T[0..16] = 255, 250, 247, 240, 235, 224, 212, 196, 181, 168, 140, 122, 102, 79, 51, 36, 0. These values are percent of full current scaled so that 255 means 100 percent.
- R7: While `enable` is low, `step`, `dir`, `mode_sel` and `both_edge` have no effect, and all outputs hold their values.
- R8: A resolution change leaves the position untouched. The legal positions for a stride s are those equal to 8 mod s. After the change, a strobe from a position off that grid lands on the nearest legal position in the step direction.
- R9: `at_origin` is high exactly when the position is 8.
- R10: Each cycle in which `step` and `enable` are both high moves the position by one stride. The new outputs appear after that rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to origin |
| enable | input | 1 | High = run, low = hold state |
| home_n | input | 1 | Active-low return to origin |
| step | input | 1 | Single-cycle step strobe |
| dir | input | 1 | 0 = clockwise (increment), 1 = counterclockwise |
| mode_sel | input | 2 | Resolution select code |
| both_edge | input | 1 | Upstream counts both clock edges (finer table) |
| pol_a | output | 1 | Phase A polarity (1 = complementary winding) |
| pol_b | output | 1 | Phase B polarity |
| amp_a | output | 8 | Phase A amplitude code |
| amp_b | output | 8 | Phase B amplitude code |
| at_origin | output | 1 | High at the phase origin |

## Verification
The hardest state to reach is a position that is off the grid of the new resolution when that resolution takes effect. The ports only allow such positions while a finer resolution is active. The stimulus therefore walks the rotor to odd positions in sixteenth-step mode, then switches to half-step or full-step mode and strobes in both directions, checking that each strobe snaps to the nearest legal position. It also crosses the quadrant boundaries and the modulo-64 wrap in both directions. That exercises the polarity flips and the zero-amplitude entries of the table.

// File: rtl/msq_pkg.sv
package msq_pkg;

    localparam int POS_W      = 6;
    localparam int AMP_W      = 8;
    localparam int QTR_W      = POS_W - 2;
    localparam int QUARTER    = 1 << QTR_W;
    localparam int ORIGIN     = QUARTER / 2;
    localparam int NUM_PHASES = 2;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [AMP_W-1:0] amp_t;
    typedef logic [QTR_W:0]   qidx_t;

    typedef enum logic [2:0] {
        RES_FULL      = 3'd0,
        RES_HALF      = 3'd1,
        RES_QUARTER   = 3'd2,
        RES_EIGHTH    = 3'd3,
        RES_SIXTEENTH = 3'd4
    } res_e;

    typedef struct packed {
        logic neg;
        amp_t amp;
    } drive_t;

    // stride in positions for a resolution
    function automatic pos_t step_size(input res_e r);
        return pos_t'(QUARTER >> int'(r));
    endfunction

    // quarter-wave amplitude, 255 = full current
    function automatic amp_t quarter_amp(input qidx_t k);
        case (k)
            5'd0:    return 8'd255;
            5'd1:    return 8'd250;
            5'd2:    return 8'd247;
            5'd3:    return 8'd240;
            5'd4:    return 8'd235;
            5'd5:    return 8'd224;
            5'd6:    return 8'd212;
            5'd7:    return 8'd196;
            5'd8:    return 8'd181;
            5'd9:    return 8'd168;
            5'd10:   return 8'd140;
            5'd11:   return 8'd122;
            5'd12:   return 8'd102;
            5'd13:   return 8'd79;
            5'd14:   return 8'd51;
            5'd15:   return 8'd36;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/msq_mode_decode.sv
module msq_mode_decode
    import msq_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic       both_edge,
    output res_e       res
);

    logic [2:0] level;

    // both-edge clocking shifts every code one resolution finer
    always_comb begin
        level = {1'b0, mode_sel} + {2'b00, both_edge};
        res   = res_e'(level);
    end

endmodule

// File: rtl/msq_position.sv
module msq_position
    import msq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic home_n,
    input  logic step,
    input  logic dir,
    input  res_e res,
    output pos_t pos
);

    pos_t inc;
    pos_t mask;
    pos_t rel;
    pos_t pos_fwd;
    pos_t pos_bwd;

    // grid for stride s is every position equal to ORIGIN mod s
    always_comb begin
        inc     = step_size(res);
        mask    = inc - pos_t'(1);
        rel     = (pos - pos_t'(ORIGIN)) & mask;
        pos_fwd = (rel == '0) ? pos + inc : pos + (inc - rel);
        pos_bwd = (rel == '0) ? pos - inc : pos - rel;
    end

    always_ff @(posedge clk) begin
        if (rst || !home_n) begin
            pos <= pos_t'(ORIGIN);
        end else if (enable && step) begin
            pos <= dir ? pos_bwd : pos_fwd;
        end
    end

    // R2: home forces origin regardless of enable
    a_r2_home_origin: assert property (@(posedge clk) disable iff (rst)
        !home_n |=> (pos == pos_t'(ORIGIN)));

    // R7: no accepted strobe means the position holds
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (home_n && !(enable && step)) |=> $stable(pos));

    // R10: an accepted strobe always moves the rotor
    a_r10_step_moves: assert property (@(posedge clk) disable iff (rst)
        (home_n && enable && step) |=> (pos != $past(pos)));

    // R8: every accepted strobe lands on the grid of the stride in force
    a_r8_on_grid: assert property (@(posedge clk) disable iff (rst)
        (home_n && enable && step) |=>
        (((pos - pos_t'(ORIGIN)) & ($past(inc) - pos_t'(1))) == '0));

    // R4: a forward strobe never travels further than one stride
    a_r4_fwd_bounded: assert property (@(posedge clk) disable iff (rst)
        (home_n && enable && step && !dir) |=>
        (pos_t'(pos - $past(pos)) <= $past(inc)));

endmodule

// File: rtl/msq_phase_map.sv
module msq_phase_map
    import msq_pkg::*;
#(
    parameter pos_t SHIFT = '0
) (
    input  pos_t   pos,
    output drive_t drv
);

    localparam qidx_t QFULL = qidx_t'(QUARTER);

    pos_t             shifted;
    logic [1:0]       quad;
    logic [QTR_W-1:0] k;
    qidx_t            idx;

    always_comb begin
        shifted = pos - SHIFT;
        quad    = shifted[POS_W-1:POS_W-2];
        k       = shifted[QTR_W-1:0];
        idx     = quad[0] ? (QFULL - {1'b0, k}) : {1'b0, k};
        drv.amp = quarter_amp(idx);
        drv.neg = quad[1] ^ quad[0];
    end

endmodule

// File: rtl/msq_sequencer.sv
module msq_sequencer
    import msq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       home_n,
    input  logic       step,
    input  logic       dir,
    input  logic [1:0] mode_sel,
    input  logic       both_edge,
    output logic       pol_a,
    output logic       pol_b,
    output logic [7:0] amp_a,
    output logic [7:0] amp_b,
    output logic       at_origin
);

    res_e   res;
    pos_t   pos;
    drive_t drv [NUM_PHASES];

    msq_mode_decode u_decode (
        .mode_sel  (mode_sel),
        .both_edge (both_edge),
        .res       (res)
    );

    msq_position u_position (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .home_n (home_n),
        .step   (step),
        .dir    (dir),
        .res    (res),
        .pos    (pos)
    );

    // each further phase lags the previous by a quarter cycle
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
        msq_phase_map #(
            .SHIFT (pos_t'(g * QUARTER))
        ) u_map (
            .pos (pos),
            .drv (drv[g])
        );
    end

    assign pol_a     = drv[0].neg;
    assign amp_a     = drv[0].amp;
    assign pol_b     = drv[1].neg;
    assign amp_b     = drv[1].amp;
    assign at_origin = (pos == pos_t'(ORIGIN));

    // R9: at the origin both windings share equal nonzero current
    a_r9_origin_balanced: assert property (@(posedge clk) disable iff (rst)
        at_origin |-> ((amp_a == amp_b) && (amp_a != '0)));

    // R5: when one phase is at zero the other is at full current
    a_r5_quadrature: assert property (@(posedge clk) disable iff (rst)
        (amp_a == '0) |-> (amp_b == '1));

endmodule

// File: tb/msq_sequencer_bench.sv
`timescale 1ns/1ps
module msq_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic       home_n = 1'b1;
    logic       step = 1'b0;
    logic       dir = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       both_edge = 1'b0;
    logic       pol_a, pol_b, at_origin;
    logic [7:0] amp_a, amp_b;

    int total = 0;
    int bad = 0;
    int mp = 8;
    bit finished = 1'b0;

    logic [18:0] exp_q[$];
    string       tag_q[$];

    int tab[17] = '{255, 250, 247, 240, 235, 224, 212, 196, 181,
                    168, 140, 122, 102, 79, 51, 36, 0};

    always #4 clk = ~clk;

    msq_sequencer u_msq_sequencer (
        .clk(clk), .rst(rst), .enable(enable), .home_n(home_n),
        .step(step), .dir(dir), .mode_sel(mode_sel), .both_edge(both_edge),
        .pol_a(pol_a), .pol_b(pol_b), .amp_a(amp_a), .amp_b(amp_b),
        .at_origin(at_origin)
    );

    // {negative, amplitude} for one phase at angle p
    function automatic logic [8:0] phase_of(input int p);
        if (p < 16)      return {1'b0, 8'(tab[p])};
        else if (p < 32) return {1'b1, 8'(tab[32 - p])};
        else if (p < 48) return {1'b1, 8'(tab[p - 32])};
        else             return {1'b0, 8'(tab[64 - p])};
    endfunction

    function automatic logic [18:0] expected(input int p);
        logic [8:0] a, b;
        a = phase_of(p);
        b = phase_of((p + 48) % 64);
        return {(p == 8), a[8], b[8], a[7:0], b[7:0]};
    endfunction

    function automatic int stride(input logic [1:0] m, input logic be);
        return 16 >> (int'(m) + int'(be));
    endfunction

    function automatic int wrap(input int x);
        return ((x % 64) + 64) % 64;
    endfunction

    // search for the next legal position, one position at a time
    function automatic int next_pos(input int p, input int s, input logic d);
        int q;
        q = p;
        for (int i = 0; i < 64; i++) begin
            q = d ? wrap(q - 1) : wrap(q + 1);
            if (wrap(q - 8) % s == 0) break;
        end
        return q;
    endfunction

    task automatic push_exp(input string tag);
        exp_q.push_back(expected(mp));
        tag_q.push_back(tag);
    endtask

    task automatic do_step(input logic d, input logic [1:0] m, input logic be,
                           input string tag);
        @(negedge clk);
        dir = d; mode_sel = m; both_edge = be; step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        if (enable) mp = next_pos(mp, stride(m, be), d);
        push_exp(tag);
    endtask

    task automatic do_home(input string tag);
        @(negedge clk);
        home_n = 1'b0;
        @(negedge clk);
        home_n = 1'b1;
        mp = 8;
        push_exp(tag);
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                logic [18:0] e;
                logic [18:0] got;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                got = {at_origin, pol_a, pol_b, amp_a, amp_b};
                total++;
                if (got !== e) begin
                    bad++;
                    $display("FAIL %s got=%h exp=%h", t, got, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mp = 8;
        push_exp("R1 reset state");

        // R3, R10: eighth step single-edge code 3, stride 2
        do_step(1'b0, 2'd3, 1'b0, "R3 eighth fwd");
        do_step(1'b0, 2'd3, 1'b0, "R3 eighth fwd");
        do_step(1'b0, 2'd3, 1'b0, "R10 eighth fwd");
        // R5, R6: sixteenth step across quadrant boundary
        do_step(1'b0, 2'd3, 1'b1, "R6 sixteenth 15");
        do_step(1'b0, 2'd3, 1'b1, "R5 quadrant flip 16");
        do_step(1'b1, 2'd3, 1'b1, "R4 reverse 15");
        // R8: off-grid then half step forward -> 16
        do_step(1'b0, 2'd1, 1'b0, "R8 snap fwd half");
        do_step(1'b0, 2'd3, 1'b1, "R8 sixteenth 17");
        // R8: full step backward from 17 -> 8
        do_step(1'b1, 2'd0, 1'b0, "R8 snap bwd full");
        // R3, R9: full step around the cycle
        do_step(1'b0, 2'd0, 1'b0, "R3 full 24");
        do_step(1'b0, 2'd0, 1'b0, "R3 full 40");
        do_step(1'b0, 2'd0, 1'b0, "R3 full 56");
        do_step(1'b0, 2'd0, 1'b0, "R9 wrap to origin");
        do_step(1'b1, 2'd0, 1'b0, "R4 wrap below zero");
        // R3: quarter step both-edge code 1, stride 4
        do_step(1'b0, 2'd1, 1'b1, "R3 quarter 60");
        do_step(1'b0, 2'd1, 1'b1, "R5 wrap to 0");

        // R10: strobe held three cycles moves three strides
        @(negedge clk);
        dir = 1'b0; mode_sel = 2'd3; both_edge = 1'b1; step = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            mp = next_pos(mp, 1, 1'b0);
            push_exp("R10 held strobe");
        end
        step = 1'b0;

        // R7: hold ignores strobes, direction and mode
        @(negedge clk);
        enable = 1'b0;
        do_step(1'b0, 2'd0, 1'b0, "R7 hold fwd");
        do_step(1'b1, 2'd2, 1'b1, "R7 hold bwd");
        // R2: home works while held
        do_home("R2 home under hold");
        @(negedge clk);
        enable = 1'b1;

        // R1: reset mid-run
        do_step(1'b1, 2'd2, 1'b1, "R1 pre-reset step");
        do_step(1'b1, 2'd2, 1'b1, "R1 pre-reset step");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mp = 8;
        push_exp("R1 reset mid-run");
        // R2: home while enabled
        do_step(1'b0, 2'd2, 1'b0, "R3 quarter single");
        do_home("R2 home enabled");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule